// File: doc/BRIEF.md
# Thread Yield Decision Unit

This unit decides what a yield request from a hardware thread does. The request has a signed source operand and a qualifier mask. The unit classifies the operand by its sign and value. It then does one of three things: it deactivates the calling context, it raises a thread fault with a cause code, or it only hands back the masked qualifier for the scheduler to use.

The unit needs the caller's binding word, the caller's status word and the virtual-processor control word. For every hardware context it also needs the binding, a dynamic-allocation flag, an activated flag and a halt flag. It returns the updated caller status word or the updated control word, each with its own write strobe, so that the register file that owns these words can commit the change. Each decision is taken from a one-cycle valid strobe, and every output is registered.

The binding word is laid out as follows. The context number occupies bits [CTX_W-1:0]. The virtual-processor number occupies the next VP_W bits above them.

Top module: `yld_unit`

## Requirements
- R1: Reset (rst_n low) clears every output to zero. After reset, `done_o` is high in exactly the cycle after a cycle in which `yld_valid_i` was high, and low otherwise.
- R2: On every `done_o` cycle, `result_o` equals the source ANDed with the mask, taken from the request cycle. While `done_o` is low, `result_o` holds its last value.
- R3: For a source of 0, a context is a match when all of the following hold: its binding equals the caller's binding in both the context field and the virtual-processor field, its dynamic-allocation flag is 1, its halt flag is 0 and its activated flag is 1. When at least one context matches, the unit raises `stat_we_o`. `stat_o` is then the caller status word with bit 0 (activated) cleared and all other bits unchanged, and no fault is raised.
- R4: For a source of 0 with no matching context, the unit raises no fault and no write strobe.
- R5: For a positive source with any set bit where the mask is 0, the unit raises `fault_o` with `cause_o` = 2. It also raises `ctrl_we_o`, and `ctrl_o` is the control word with bits [6:4] replaced by 2 and all other bits unchanged.
- R6: For a positive source whose set bits all lie inside the mask, the unit raises no fault and no write strobe.
- R7: For a negative source other than -2, when control bit 0 (yield-scheduling interrupt enable) is 1 and caller status bit 2 (dirty) is 1, the unit raises `fault_o` with `cause_o` = 4. It also raises `ctrl_we_o`, and `ctrl_o` is the control word with bits [6:4] replaced by 4.
- R8: For a negative source other than -2 where either of those two bits is 0, the unit raises no fault and no write strobe.
- R9: A source of -2 raises no fault and no write strobe, whatever the other inputs are.
- R10: On a `done_o` cycle without a fault, `cause_o` is 0. A fault and a status write never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| yld_valid_i | input | 1 | Yield request strobe |
| yld_src_i | input | DATA_W | Signed source operand |
| yld_mask_i | input | DATA_W | Yield qualifier mask |
| self_bind_i | input | BIND_W | Caller binding word |
| self_stat_i | input | STAT_W | Caller status word (bit0 activated, bit2 dirty) |
| ctrl_i | input | CTRL_W | Control word (bit0 interrupt enable, bits[6:4] cause) |
| ctx_bind_i | input | NCTX*BIND_W | Binding of each context, context i at slice i |
| ctx_dyn_i | input | NCTX | Dynamic-allocation flag for each context |
| ctx_act_i | input | NCTX | Activated flag for each context |
| ctx_halt_i | input | NCTX | Halt flag for each context |
| done_o | output | 1 | Decision valid |
| fault_o | output | 1 | Thread fault raised |
| cause_o | output | CAUSE_W | Fault cause code (0 when there is no fault) |
| result_o | output | DATA_W | Source ANDed with the mask |
| stat_we_o | output | 1 | Caller status write strobe |
| stat_o | output | STAT_W | Updated caller status word |
| ctrl_we_o | output | 1 | Control word write strobe |
| ctrl_o | output | CTRL_W | Updated control word |

## Verification
The bench targets the operand values at the edges of each class:

- **0, 1, the most negative value, -1, -2 and -3.** A misplaced sign test or a wrong compare against -2 would send one of these operands down the wrong path. The effect would be a spurious fault or a missing deactivation.
- **Near-miss contexts for a source of 0.** These contexts differ from a true match in just one of the five match conditions. A design that drops any of those terms would deactivate a caller it should leave alone.
- **Masks that cover the source exactly, and masks that miss it by one bit.** These reveal a wrong complement of the mask, which would fault on legal yields or pass illegal ones.
- **The enable and dirty combinations on the negative path.** These catch a design that tests only one of the two bits.

// File: rtl/yld_pkg.sv
package yld_pkg;
    localparam int STAT_W      = 8;
    localparam int ST_ACT      = 0;
    localparam int ST_DIRTY    = 2;
    localparam int CTRL_W      = 8;
    localparam int CT_YSI      = 0;
    localparam int CT_CAUSE_LO = 4;
    localparam int CAUSE_W     = 3;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE  = 3'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_MASK  = 3'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_SCHED = 3'd4;

    typedef enum logic [1:0] {
        K_ZERO = 2'd0,
        K_POS  = 2'd1,
        K_NEG  = 2'd2,
        K_SKIP = 2'd3
    } yld_kind_e;
endpackage

// File: rtl/yld_classify.sv
module yld_classify
    import yld_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] src_i,
    output yld_kind_e         kind_o
);
    localparam logic [DATA_W-1:0] MINUS_TWO = {{(DATA_W-1){1'b1}}, 1'b0};

    always_comb begin
        if (src_i == '0)
            kind_o = K_ZERO;
        else if (!src_i[DATA_W-1])
            kind_o = K_POS;
        else if (src_i == MINUS_TWO)
            kind_o = K_SKIP;
        else
            kind_o = K_NEG;
    end
endmodule

// File: rtl/yld_match.sv
module yld_match #(
    parameter int NCTX   = 8,
    parameter int BIND_W = 5
) (
    input  logic [BIND_W-1:0]      self_bind_i,
    input  logic [NCTX*BIND_W-1:0] ctx_bind_i,
    input  logic [NCTX-1:0]        ctx_dyn_i,
    input  logic [NCTX-1:0]        ctx_act_i,
    input  logic [NCTX-1:0]        ctx_halt_i,
    output logic                   hit_o
);
    logic [NCTX-1:0] hit_vec;

    for (genvar i = 0; i < NCTX; i++) begin : g_ctx
        assign hit_vec[i] = (ctx_bind_i[i*BIND_W +: BIND_W] == self_bind_i)
                          && ctx_dyn_i[i] && !ctx_halt_i[i] && ctx_act_i[i];
    end

    assign hit_o = |hit_vec;
endmodule

// File: rtl/yld_unit.sv
module yld_unit
    import yld_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NCTX   = 8,
    parameter int VP_W   = 2,
    parameter int CTX_W  = $clog2(NCTX),
    parameter int BIND_W = CTX_W + VP_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   yld_valid_i,
    input  logic [DATA_W-1:0]      yld_src_i,
    input  logic [DATA_W-1:0]      yld_mask_i,
    input  logic [BIND_W-1:0]      self_bind_i,
    input  logic [STAT_W-1:0]      self_stat_i,
    input  logic [CTRL_W-1:0]      ctrl_i,
    input  logic [NCTX*BIND_W-1:0] ctx_bind_i,
    input  logic [NCTX-1:0]        ctx_dyn_i,
    input  logic [NCTX-1:0]        ctx_act_i,
    input  logic [NCTX-1:0]        ctx_halt_i,
    output logic                   done_o,
    output logic                   fault_o,
    output logic [CAUSE_W-1:0]     cause_o,
    output logic [DATA_W-1:0]      result_o,
    output logic                   stat_we_o,
    output logic [STAT_W-1:0]      stat_o,
    output logic                   ctrl_we_o,
    output logic [CTRL_W-1:0]      ctrl_o
);
    typedef struct packed {
        logic               done;
        logic               fault;
        logic [CAUSE_W-1:0] cause;
        logic [DATA_W-1:0]  result;
        logic               stat_we;
        logic [STAT_W-1:0]  stat;
        logic               ctrl_we;
        logic [CTRL_W-1:0]  ctrl;
    } yld_out_t;

    yld_kind_e kind;
    logic      ctx_hit;
    yld_out_t  out_d, out_q;

    yld_classify #(.DATA_W(DATA_W)) u_class (
        .src_i  (yld_src_i),
        .kind_o (kind)
    );

    yld_match #(.NCTX(NCTX), .BIND_W(BIND_W)) u_match (
        .self_bind_i (self_bind_i),
        .ctx_bind_i  (ctx_bind_i),
        .ctx_dyn_i   (ctx_dyn_i),
        .ctx_act_i   (ctx_act_i),
        .ctx_halt_i  (ctx_halt_i),
        .hit_o       (ctx_hit)
    );

    always_comb begin
        out_d         = out_q;
        out_d.done    = 1'b0;
        out_d.fault   = 1'b0;
        out_d.stat_we = 1'b0;
        out_d.ctrl_we = 1'b0;
        if (yld_valid_i) begin
            out_d.done   = 1'b1;
            out_d.result = yld_src_i & yld_mask_i;
            out_d.cause  = CAUSE_NONE;
            unique case (kind)
                K_ZERO: begin
                    if (ctx_hit) begin
                        out_d.stat_we        = 1'b1;
                        out_d.stat           = self_stat_i;
                        out_d.stat[ST_ACT]   = 1'b0;
                    end
                end
                K_POS: begin
                    if ((yld_src_i & ~yld_mask_i) != '0) begin
                        out_d.fault   = 1'b1;
                        out_d.cause   = CAUSE_MASK;
                        out_d.ctrl_we = 1'b1;
                        out_d.ctrl    = ctrl_i;
                        out_d.ctrl[CT_CAUSE_LO +: CAUSE_W] = CAUSE_MASK;
                    end
                end
                K_NEG: begin
                    if (ctrl_i[CT_YSI] && self_stat_i[ST_DIRTY]) begin
                        out_d.fault   = 1'b1;
                        out_d.cause   = CAUSE_SCHED;
                        out_d.ctrl_we = 1'b1;
                        out_d.ctrl    = ctrl_i;
                        out_d.ctrl[CT_CAUSE_LO +: CAUSE_W] = CAUSE_SCHED;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign done_o    = out_q.done;
    assign fault_o   = out_q.fault;
    assign cause_o   = out_q.cause;
    assign result_o  = out_q.result;
    assign stat_we_o = out_q.stat_we;
    assign stat_o    = out_q.stat;
    assign ctrl_we_o = out_q.ctrl_we;
    assign ctrl_o    = out_q.ctrl;
endmodule

// File: rtl/yld_chk.sv
module yld_chk
    import yld_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               yld_valid_i,
    input logic [DATA_W-1:0]  yld_src_i,
    input logic [DATA_W-1:0]  yld_mask_i,
    input logic               done_o,
    input logic               fault_o,
    input logic [CAUSE_W-1:0] cause_o,
    input logic [DATA_W-1:0]  result_o,
    input logic               stat_we_o,
    input logic               ctrl_we_o
);
    localparam logic [DATA_W-1:0] MINUS_TWO = {{(DATA_W-1){1'b1}}, 1'b0};

    a_r1_done_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
        yld_valid_i |=> done_o);
    a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !yld_valid_i |=> !done_o);
    a_r2_result_masked: assert property (@(posedge clk) disable iff (!rst_n)
        yld_valid_i |=> (result_o == $past(yld_src_i & yld_mask_i)));
    a_r2_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!yld_valid_i && done_o) |=> $stable(result_o) || done_o);
    a_r9_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (yld_valid_i && yld_src_i == MINUS_TWO) |=> !fault_o && !stat_we_o && !ctrl_we_o);
    a_r10_cause_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o) |-> cause_o == CAUSE_NONE);
    a_r10_fault_excl_stat: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_o && stat_we_o));
    a_r5_fault_cause_legal: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (ctrl_we_o && done_o && (cause_o == CAUSE_MASK || cause_o == CAUSE_SCHED)));
endmodule

bind yld_unit yld_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .yld_valid_i (yld_valid_i),
    .yld_src_i   (yld_src_i),
    .yld_mask_i  (yld_mask_i),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .cause_o     (cause_o),
    .result_o    (result_o),
    .stat_we_o   (stat_we_o),
    .ctrl_we_o   (ctrl_we_o)
);

// File: tb/yld_unit_tb.sv
module yld_unit_tb_top;
    localparam int DW = 16, NC = 8, VPW = 2, CW = 3, BW = 5, SW = 8, TW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic yld_valid_i = 1'b0;
    logic [DW-1:0] yld_src_i = '0, yld_mask_i = '0;
    logic [BW-1:0] self_bind_i = '0;
    logic [SW-1:0] self_stat_i = '0;
    logic [TW-1:0] ctrl_i = '0;
    logic [NC*BW-1:0] ctx_bind_i = '0;
    logic [NC-1:0] ctx_dyn_i = '0, ctx_act_i = '0, ctx_halt_i = '0;
    logic done_o, fault_o, stat_we_o, ctrl_we_o;
    logic [2:0] cause_o;
    logic [DW-1:0] result_o;
    logic [SW-1:0] stat_o;
    logic [TW-1:0] ctrl_o;

    int checks = 0, failures = 0;
    logic [DW-1:0] last_res = '0;

    always #10 clk = ~clk;

    yld_unit #(.DATA_W(DW), .NCTX(NC), .VP_W(VPW)) dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit model_hit();
        for (int i = 0; i < NC; i++)
            if (ctx_bind_i[i*BW +: BW] == self_bind_i && ctx_dyn_i[i] && !ctx_halt_i[i] && ctx_act_i[i])
                return 1'b1;
        return 1'b0;
    endfunction

    task automatic run_one();
        logic exp_f, exp_sw, exp_cw;
        logic [2:0] exp_c;
        logic [SW-1:0] exp_s;
        logic [TW-1:0] exp_ct;
        string tag;
        exp_f = 0; exp_sw = 0; exp_cw = 0; exp_c = 0;
        exp_s = self_stat_i & 8'hFE; exp_ct = ctrl_i;
        if (yld_src_i == 0) begin
            exp_sw = model_hit(); tag = exp_sw ? "R3" : "R4";
        end else if (!yld_src_i[DW-1]) begin
            if ((yld_src_i & ~yld_mask_i) != 0) begin
                exp_f = 1; exp_c = 2; exp_cw = 1; tag = "R5";
            end else tag = "R6";
        end else if (yld_src_i == 16'hFFFE) begin
            tag = "R9";
        end else if (ctrl_i[0] && self_stat_i[2]) begin
            exp_f = 1; exp_c = 4; exp_cw = 1; tag = "R7";
        end else tag = "R8";
        exp_ct[6:4] = exp_c;
        yld_valid_i = 1'b1;
        @(posedge clk); @(negedge clk);
        yld_valid_i = 1'b0;
        chk("R1 done", done_o, 1);
        chk("R2 result", result_o, yld_src_i & yld_mask_i);
        last_res = yld_src_i & yld_mask_i;
        chk({tag, " fault"}, fault_o, exp_f);
        chk({tag, " stat_we"}, stat_we_o, exp_sw);
        chk({tag, " ctrl_we"}, ctrl_we_o, exp_cw);
        chk({"R10 ", tag, " cause"}, cause_o, exp_c);
        if (exp_sw) chk("R3 stat", stat_o, exp_s);
        if (exp_cw) chk({tag, " ctrl"}, ctrl_o, exp_ct);
    endtask

    task automatic rand_ctx(input bit plant, input int miss);
        int k;
        for (int i = 0; i < NC; i++) ctx_bind_i[i*BW +: BW] = BW'($urandom);
        ctx_dyn_i = NC'($urandom); ctx_act_i = NC'($urandom); ctx_halt_i = NC'($urandom);
        for (int i = 0; i < NC; i++)
            if (ctx_bind_i[i*BW +: BW] == self_bind_i) ctx_bind_i[i*BW] = ~self_bind_i[0];
        if (plant) begin
            k = int'($urandom_range(NC-1));
            ctx_bind_i[k*BW +: BW] = self_bind_i;
            ctx_dyn_i[k] = 1; ctx_act_i[k] = 1; ctx_halt_i[k] = 0;
            case (miss)
                1: ctx_bind_i[k*BW] = ~self_bind_i[0];
                2: ctx_bind_i[k*BW+BW-1] = ~self_bind_i[BW-1];
                3: ctx_dyn_i[k] = 0;
                4: ctx_act_i[k] = 0;
                5: ctx_halt_i[k] = 1;
                default: ;
            endcase
        end
    endtask

    initial begin
        int unused = $urandom(32'h5eed1);
        #100000000;
        failures++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 reset done", done_o, 0);
        chk("R1 reset fault", fault_o, 0);
        chk("R1 reset result", result_o, 0);
        chk("R1 reset stat_we", stat_we_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle done", done_o, 0);
        // directed corners
        self_bind_i = 5'h0B; self_stat_i = 8'h5D; ctrl_i = 8'h81; yld_mask_i = 16'h00F0;
        for (int m = 0; m <= 5; m++) begin
            rand_ctx(1'b1, m); yld_src_i = 0; run_one();
        end
        foreach (yld_src_i[b]) ;
        yld_src_i = 16'h0001; run_one();
        yld_src_i = 16'h00F0; run_one();
        yld_src_i = 16'h01F0; run_one();
        yld_src_i = 16'h8000; run_one();
        yld_src_i = 16'hFFFF; run_one();
        yld_src_i = 16'hFFFE; run_one();
        yld_src_i = 16'hFFFD; run_one();
        for (int c = 0; c < 4; c++) begin
            ctrl_i[0] = c[0]; self_stat_i[2] = c[1]; yld_src_i = 16'hFFF0; run_one();
            yld_src_i = 16'hFFFE; run_one();
        end
        // hold check
        @(negedge clk);
        chk("R1 gap done", done_o, 0);
        chk("R2 hold", result_o, last_res);
        // random
        for (int n = 0; n < 600; n++) begin
            int sel = int'($urandom_range(5));
            self_bind_i = BW'($urandom); self_stat_i = SW'($urandom); ctrl_i = TW'($urandom);
            yld_mask_i = DW'($urandom);
            rand_ctx($urandom_range(1) == 1, int'($urandom_range(7)));
            case (sel)
                0: yld_src_i = 0;
                1: yld_src_i = 16'hFFFE;
                2: yld_src_i = yld_mask_i & 16'h7FFF;
                3: yld_src_i = 16'h7FFF & DW'($urandom);
                default: yld_src_i = 16'h8000 | DW'($urandom);
            endcase
            run_one();
            if (n % 50 == 0) begin
                @(negedge clk);
                chk("R2 hold idle", result_o, last_res);
                chk("R1 idle", done_o, 0);
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule